// File: doc/BRIEF.md
# Camera Control Serial Bus Master

This block is a two-wire master for configuring camera sensors. Control logic loads timing, framing and payload registers over a simple register-write port and then sets a start bit. The engine generates a start condition and shifts out a fixed group of bytes, most significant bit first, each followed by a ninth acknowledge slot. It finishes with a stop condition and then clears the busy bit by itself. SCL low and high times are counted in system clocks from two separate 8-bit counts.

Reading a sensor register takes two launches. The first is an address-only write: the device byte with bit 0 set, then one register address byte, or two bytes for a 16-bit address. The second launch sends the device byte with bit 0 clear. The engine then releases SDA for eight bit times, shifts in the byte the device returns, and sends a NACK. The returned byte is held on `rd_data` until the next read completes.

Top module: `sccb_master`

## Requirements
- R1: After reset `scl_o` and `sda_o` are 1, `busy` is 0, `rd_data` is 0, and both SCL counts are 255. The first transaction after reset therefore runs with 255-clock low and high phases.
- R2: Writing `reg_sel`=0 loads the low count from bits [7:0] and the high count from bits [15:8]. Every SCL low phase then lasts the low count in clocks, and every SCL high phase inside a byte lasts the high count. A count of 0 acts as 1.
- R3: Bits [17:16] of register 0 set the length of a write: 0 gives 2 bytes, 1 gives 3 bytes, 2 or 3 gives 4 bytes. Bytes are sent in this order: device byte (`reg_sel`=1 bits [7:0]), register byte (bits [15:8]), byte at bits [23:16], byte at bits [31:24].
- R4: A transaction opens with SDA falling while SCL is high and closes with SDA rising while SCL is high. SDA changes at no other time while SCL is high.
- R5: `busy` is 1 from the clock after an accepted start until the stop condition has been sent, and then returns to 0 without any further write.
- R6: A write to `reg_sel`=2 launches a transaction only when bit 0 (start) and bit 1 (its write enable) are both 1. With bit 1 clear, or with bit 0 clear, the write changes nothing.
- R7: A start request written while `busy` is 1 is ignored: no second transaction follows.
- R8: When device-byte bit 0 is 0, the transaction sends only the device byte, releases SDA for eight bits, shifts in the line value sampled at the end of each SCL high phase, and releases the ninth slot (NACK). The byte is then presented on `rd_data`.
- R9: The master releases SDA (drives 1) in the ninth slot of every byte it sends.
- R10: `rd_data` keeps its value across write transactions and changes only at the end of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 timing, 1 frame, 2 control |
| reg_wdata | input | 32 | Register write data |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_o | output | 1 | SCL level |
| sda_o | output | 1 | SDA drive, 1 means released |
| busy | output | 1 | Transaction in progress |
| rd_data | output | 8 | Last byte returned by a read |

## Verification
The scoreboard decodes the wire-ANDed bus into start, 9-bit groups and stop, and compares them against the bytes queued by the driver. This catches a design that sends bytes in the wrong order or the wrong number of them for each length code, or that drives the acknowledge slot low. Phase widths are measured at the default count of 255 and at small asymmetric counts; a design that swapped the two counts, or added a cycle to each phase, fails these checks. Start requests without the write enable, and requests sent mid-transaction, are followed by a quiet window, so a design that launches a second frame is caught. A read with a slave-driven byte, followed by a write, shows whether `rd_data` is captured on the correct edge and then held.

// File: rtl/sccb_pkg.sv
package sccb_pkg;
    localparam int CNT_W  = 8;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 4 * BYTE_W;
    localparam int BIT_W  = 4;
    localparam int CODE_W = 2;

    localparam logic [1:0] REG_TIMING = 2'd0;
    localparam logic [1:0] REG_FRAME  = 2'd1;
    localparam logic [1:0] REG_CTRL   = 2'd2;

    localparam int START_BIT    = 0;
    localparam int START_WE_BIT = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_LO,
        ST_HI,
        ST_STP_LO,
        ST_STP_HI,
        ST_STP_END
    } seq_state_e;

    typedef struct packed {
        logic [CNT_W-1:0]  lo_cnt;
        logic [CNT_W-1:0]  hi_cnt;
        logic [CODE_W-1:0] len_code;
        logic [BYTE_W-1:0] dev;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] dat0;
        logic [BYTE_W-1:0] dat1;
    } cfg_t;
endpackage

// File: rtl/sccb_cfg_regs.sv
module sccb_cfg_regs
    import sccb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             done,
    output cfg_t             cfg,
    output logic             busy,
    output logic             launch
);
    typedef struct packed {
        cfg_t cfg;
        logic busy;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        launch = 1'b0;
        if (reg_we) begin
            case (reg_sel)
                REG_TIMING: begin
                    r_d.cfg.lo_cnt   = reg_wdata[CNT_W-1:0];
                    r_d.cfg.hi_cnt   = reg_wdata[2*CNT_W-1:CNT_W];
                    r_d.cfg.len_code = reg_wdata[2*CNT_W+CODE_W-1:2*CNT_W];
                end
                REG_FRAME: begin
                    r_d.cfg.dev  = reg_wdata[BYTE_W-1:0];
                    r_d.cfg.addr = reg_wdata[2*BYTE_W-1:BYTE_W];
                    r_d.cfg.dat0 = reg_wdata[3*BYTE_W-1:2*BYTE_W];
                    r_d.cfg.dat1 = reg_wdata[4*BYTE_W-1:3*BYTE_W];
                end
                REG_CTRL: begin
                    if (reg_wdata[START_WE_BIT] && reg_wdata[START_BIT] && !r_q.busy) begin
                        r_d.busy = 1'b1;
                        launch   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (done) begin
            r_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q              <= '0;
            r_q.cfg.lo_cnt   <= '1;
            r_q.cfg.hi_cnt   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg  = r_q.cfg;
    assign busy = r_q.busy;

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && !done) |=> r_q.busy); // R5

    AST_START_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.busy) |-> $past(reg_we && reg_sel == REG_CTRL
                                  && reg_wdata[START_WE_BIT] && reg_wdata[START_BIT])); // R6
endmodule

// File: rtl/sccb_bit_timer.sv
module sccb_bit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] eff_len;

    always_comb begin
        eff_len = (len == '0) ? ONE : len;
        expire  = (cnt_q >= eff_len - ONE);
        if (clr) begin
            cnt_d = '0;
        end else if (expire) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sccb_seq.sv
module sccb_seq
    import sccb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  cfg_t              cfg,
    input  logic              sda_in,
    input  logic              expire,
    output logic              tmr_clr,
    output logic [CNT_W-1:0]  tmr_len,
    output logic              scl_o,
    output logic              sda_o,
    output logic              done,
    output logic [BYTE_W-1:0] rd_data
);
    localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_W);

    typedef struct packed {
        seq_state_e        state;
        logic [1:0]        byte_idx;
        logic [1:0]        last_idx;
        logic [BIT_W-1:0]  bit_idx;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] rd;
        logic              is_read;
    } seq_t;

    seq_t s_d, s_q;
    logic rx_phase;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [1:0] idx, input cfg_t c);
        case (idx)
            2'd0:    return c.dev;
            2'd1:    return c.addr;
            2'd2:    return c.dat0;
            default: return c.dat1;
        endcase
    endfunction

    always_comb begin
        s_d      = s_q;
        done     = 1'b0;
        tmr_clr  = 1'b0;
        rx_phase = s_q.is_read && (s_q.byte_idx == 2'd1);
        tmr_len  = (s_q.state == ST_LO || s_q.state == ST_STP_LO) ? cfg.lo_cnt : cfg.hi_cnt;

        case (s_q.state)
            ST_IDLE: begin
                tmr_clr = 1'b1;
                if (launch) begin
                    s_d.state    = ST_START;
                    s_d.byte_idx = 2'd0;
                    s_d.bit_idx  = '0;
                    s_d.sh       = cfg.dev;
                    s_d.is_read  = !cfg.dev[0];
                    if (!cfg.dev[0]) begin
                        s_d.last_idx = 2'd1;
                    end else begin
                        case (cfg.len_code)
                            2'd0:    s_d.last_idx = 2'd1;
                            2'd1:    s_d.last_idx = 2'd2;
                            default: s_d.last_idx = 2'd3;
                        endcase
                    end
                end
            end
            ST_START: begin
                if (expire) begin
                    s_d.state = ST_LO;
                    tmr_clr   = 1'b1;
                end
            end
            ST_LO: begin
                if (expire) begin
                    s_d.state = ST_HI;
                    tmr_clr   = 1'b1;
                end
            end
            ST_HI: begin
                if (expire) begin
                    tmr_clr = 1'b1;
                    if (s_q.bit_idx != ACK_SLOT) begin
                        if (rx_phase) begin
                            s_d.rx = {s_q.rx[BYTE_W-2:0], sda_in};
                        end
                        s_d.bit_idx = s_q.bit_idx + 1'b1;
                        s_d.sh      = {s_q.sh[BYTE_W-2:0], 1'b0};
                        s_d.state   = ST_LO;
                    end else if (s_q.byte_idx == s_q.last_idx) begin
                        s_d.state = ST_STP_LO;
                    end else begin
                        s_d.byte_idx = s_q.byte_idx + 1'b1;
                        s_d.bit_idx  = '0;
                        s_d.sh       = pick_byte(s_q.byte_idx + 1'b1, cfg);
                        s_d.state    = ST_LO;
                    end
                end
            end
            ST_STP_LO: begin
                if (expire) begin
                    s_d.state = ST_STP_HI;
                    tmr_clr   = 1'b1;
                end
            end
            ST_STP_HI: begin
                if (expire) begin
                    s_d.state = ST_STP_END;
                    tmr_clr   = 1'b1;
                end
            end
            ST_STP_END: begin
                if (expire) begin
                    s_d.state = ST_IDLE;
                    tmr_clr   = 1'b1;
                    done      = 1'b1;
                    if (s_q.is_read) begin
                        s_d.rd = s_q.rx;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_comb begin
        scl_o = !(s_q.state == ST_LO || s_q.state == ST_STP_LO);
        case (s_q.state)
            ST_START, ST_STP_LO, ST_STP_HI: sda_o = 1'b0;
            ST_LO, ST_HI: begin
                if (s_q.bit_idx == ACK_SLOT || rx_phase) begin
                    sda_o = 1'b1;
                end else begin
                    sda_o = s_q.sh[BYTE_W-1];
                end
            end
            default: sda_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rd;

    AST_SDA_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && (sda_o != $past(sda_o))) |->
        ((s_q.state == ST_START && $past(s_q.state) == ST_IDLE) ||
         (s_q.state == ST_STP_END && $past(s_q.state) == ST_STP_HI))); // R4

    AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state != ST_IDLE) |-> (s_q.byte_idx <= s_q.last_idx)); // R3

    AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.state == ST_LO || s_q.state == ST_HI) && s_q.bit_idx == ACK_SLOT) |-> sda_o); // R9

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state != ST_IDLE || $past(s_q.state) != ST_STP_END) |-> $stable(rd_data)); // R10
endmodule

// File: rtl/sccb_master.sv
module sccb_master
    import sccb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              sda_in,
    output logic              scl_o,
    output logic              sda_o,
    output logic              busy,
    output logic [BYTE_W-1:0] rd_data
);
    cfg_t             cfg;
    logic             launch;
    logic             done;
    logic             expire;
    logic             tmr_clr;
    logic [CNT_W-1:0] tmr_len;

    sccb_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .done      (done),
        .cfg       (cfg),
        .busy      (busy),
        .launch    (launch)
    );

    sccb_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .len    (tmr_len),
        .expire (expire)
    );

    sccb_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .cfg     (cfg),
        .sda_in  (sda_in),
        .expire  (expire),
        .tmr_clr (tmr_clr),
        .tmr_len (tmr_len),
        .scl_o   (scl_o),
        .sda_o   (sda_o),
        .done    (done),
        .rd_data (rd_data)
    );

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && sda_o)); // R1
endmodule

// File: tb/sccb_master_tb_top.sv
module sccb_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic        slave_low;
    logic        sda_line;
    logic        scl_o, sda_o, busy;
    logic [7:0]  rd_data;

    always #10 clk = ~clk;

    assign sda_line = sda_o & ~slave_low;

    sccb_master dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .sda_in    (sda_line),
        .scl_o     (scl_o),
        .sda_o     (sda_o),
        .busy      (busy),
        .rd_data   (rd_data)
    );

    int          checks = 0;
    int          fails = 0;
    logic [9:0]  exp_q[$];
    string       tag_q[$];
    int          exp_lo = 255;
    int          exp_hi = 255;
    logic        p_scl = 1'b1, p_sda = 1'b1;
    int          run = 1;
    int          nb = 0;
    int          starts = 0, stops = 0;
    int          tim_err = 0, tim_cnt = 0;
    logic [8:0]  cur9 = '0;
    logic        rd_tx = 1'b0;
    logic        in_tx = 1'b0;
    logic [7:0]  slave_byte = 8'h00;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic sb_pop(input logic [9:0] item);
        logic [9:0] e;
        string      t;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected bus item", {22'h0, item}, 32'h0);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(item == e, t, {22'h0, item}, {22'h0, e});
        end
    endtask

    // monitor: decode bus, measure phases, model slave for reads
    always @(negedge clk) begin
        if (!rst_n) begin
            p_scl     = 1'b1;
            p_sda     = 1'b1;
            run       = 1;
            slave_low = 1'b0;
        end else begin
            if (scl_o && p_scl && p_sda && !sda_line) begin
                starts++;
                nb    = 0;
                rd_tx = 1'b0;
                in_tx = 1'b1;
            end else if (scl_o && p_scl && !p_sda && sda_line) begin
                stops++;
                in_tx = 1'b0;
                sb_pop({1'b1, 9'h000});
            end
            if (scl_o != p_scl) begin
                if (in_tx) begin
                    if (scl_o) begin
                        tim_cnt++;
                        if (run != exp_lo) tim_err++;
                        cur9 = {cur9[7:0], sda_line};
                        nb++;
                        if (nb == 8) rd_tx = ~sda_line;
                        if (nb % 9 == 0) sb_pop({1'b0, cur9});
                    end else begin
                        if (nb > 0) begin
                            tim_cnt++;
                            if (run != exp_hi) tim_err++;
                        end
                        if (rd_tx && nb >= 9 && nb <= 16) slave_low = ~slave_byte[16 - nb];
                        else slave_low = 1'b0;
                    end
                end
                run = 1;
            end else begin
                run++;
            end
            p_scl = scl_o;
            p_sda = sda_o & ~slave_low;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_sel   = sel;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input string tag);
        exp_q.push_back({1'b0, b, 1'b1});
        tag_q.push_back(tag);
    endtask

    task automatic push_stop(input string tag);
        exp_q.push_back({1'b1, 9'h000});
        tag_q.push_back(tag);
    endtask

    task automatic set_timing(input int lo, input int hi, input logic [1:0] code);
        wr(2'd0, {14'h0, code, hi[7:0], lo[7:0]});
        exp_lo = lo;
        exp_hi = hi;
    endtask

    task automatic launch(input string tag);
        tim_err = 0;
        tim_cnt = 0;
        wr(2'd2, 32'h3);
        chk(busy == 1'b1, {tag, " busy set after start (R5)"}, {31'h0, busy}, 32'h1);
    endtask

    task automatic finish_tx(input string tag);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " busy cleared only after stop (R5)"}, exp_q.size(), 32'h0);
        chk(tim_err == 0 && tim_cnt > 0, {tag, " SCL phase widths (R2)"}, tim_err, 32'h0);
    endtask

    task automatic do_write(input logic [7:0] dev, input logic [7:0] ra, input logic [7:0] d0,
                            input logic [7:0] d1, input int n, input string tag);
        wr(2'd1, {d1, d0, ra, dev});
        push(dev, {tag, " device byte and ack release (R3 R9)"});
        push(ra, {tag, " register byte (R3)"});
        if (n >= 3) push(d0, {tag, " third byte (R3)"});
        if (n == 4) push(d1, {tag, " fourth byte (R3)"});
        push_stop({tag, " stop condition (R4)"});
        launch(tag);
        finish_tx(tag);
    endtask

    task automatic do_read(input logic [7:0] dev, input logic [7:0] sb, input string tag);
        slave_byte = sb;
        wr(2'd1, {24'h0, dev & 8'hFE});
        push(dev & 8'hFE, {tag, " read device byte (R8)"});
        push(sb, {tag, " read data and NACK (R8)"});
        push_stop({tag, " read stop (R4)"});
        launch(tag);
        finish_tx(tag);
        chk(rd_data == sb, {tag, " rd_data captured (R8)"}, {24'h0, rd_data}, {24'h0, sb});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int s0;
        rst_n     = 1'b0;
        reg_we    = 1'b0;
        reg_sel   = 2'd0;
        reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_o && sda_o, "R1 lines released after reset", {30'h0, scl_o, sda_o}, 32'h3);
        chk(!busy, "R1 busy clear after reset", {31'h0, busy}, 32'h0);
        chk(rd_data == 8'h00, "R1 rd_data zero after reset", {24'h0, rd_data}, 32'h0);

        // R1 default counts of 255, 2-byte address-only write
        do_write(8'h61, 8'h12, 8'h00, 8'h00, 2, "R1");

        set_timing(4, 3, 2'd1);
        do_write(8'h61, 8'h3C, 8'h32, 8'h00, 3, "R3 three-byte");

        set_timing(3, 4, 2'd2);
        do_write(8'h61, 8'h30, 8'h0A, 8'h5C, 4, "R3 four-byte");

        set_timing(3, 4, 2'd3);
        do_write(8'hA5, 8'h81, 8'h7E, 8'hC3, 4, "R3 code3");

        set_timing(2, 5, 2'd0);
        do_write(8'h61, 8'h1D, 8'hFF, 8'hFF, 2, "R2 asym");

        do_read(8'h61, 8'hA2, "R8 first");
        do_write(8'h61, 8'h0A, 8'h00, 8'h00, 2, "R10 addr");
        chk(rd_data == 8'hA2, "R10 rd_data held over write", {24'h0, rd_data}, 32'hA2);
        do_read(8'h60, 8'h3C, "R8 second");

        // R6: start without write enable, and enable with zero value
        s0 = starts;
        wr(2'd2, 32'h1);
        repeat (8) @(negedge clk);
        chk(!busy && starts == s0 && scl_o && sda_o, "R6 start without enable ignored",
            {31'h0, busy}, 32'h0);
        wr(2'd2, 32'h2);
        repeat (8) @(negedge clk);
        chk(!busy && starts == s0, "R6 enable with zero start ignored", starts - s0, 32'h0);

        // R7: second start during a transaction
        set_timing(3, 3, 2'd1);
        wr(2'd1, {8'h00, 8'h22, 8'h11, 8'h43});
        push(8'h43, "R7 device byte");
        push(8'h11, "R7 register byte");
        push(8'h22, "R7 data byte");
        push_stop("R7 stop");
        launch("R7");
        repeat (20) @(negedge clk);
        s0 = starts;
        wr(2'd2, 32'h3);
        finish_tx("R7");
        repeat (60) @(negedge clk);
        chk(starts == s0 && !busy, "R7 start while busy ignored", starts - s0, 32'h0);
        chk(exp_q.size() == 0, "R7 no extra bus items", exp_q.size(), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule